// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the line status bits of one UART channel. It sits between the serial receiver and transmitter on one side and the receive and transmit FIFOs on the other. The receiver reports each finished character with a one-cycle strobe. The strobe carries the parity, framing and break results for that character. The block decides whether the character may enter the receive FIFO, and it tags each entry with its three error results. The status bits it shows always describe the entry at the head of the FIFO.

On the transmit side the block tracks whether the holding stage (a holding register, or the transmit FIFO) can take another byte. It also tracks whether the whole transmitter has gone quiet. From these it raises the transmit-empty interrupt request when that interrupt is enabled. The FIFO storage and the serial shifters are not part of this block. They appear only as flags and strobes at its ports.

Top module: `uart_lsr_track`

## Requirements
- R1: `lsr_dr` is 1 exactly when `rxf_empty` is 0, so it is 0 while the receive FIFO reports empty.
- R2: When `rx_done` arrives and the character is accepted, `rxf_push` is 1 in the same cycle only if `rxf_full` is 0. An accepted character that arrives while `rxf_full` is 1 is not pushed, and `lsr_oe` is 1 from the next cycle.
- R3: `lsr_oe` stays set until a cycle with `host_rd_lsr` high, and it reads 0 from the following cycle. When a new overrun happens in that same read cycle, `lsr_oe` stays 1.
- R4: `rxf_push_tag` carries the receiver result, with bit 0 for parity error, bit 1 for framing error and bit 2 for break. `lsr_pe` and `lsr_fe` equal bits 0 and 1 of `rxf_head_tag` while the FIFO is not empty, and they are 0 while it is empty.
- R5: The first break character is accepted and sets a break-hold state from the next cycle. A break character that completes while that hold is set is dropped. It is not pushed and it does not cause an overrun.
- R6: The break-hold state is cleared in the cycle after one where `rx_line` is 1 and no break character completes. `lsr_bi` is the break-hold state OR'd with bit 2 of the head tag when the FIFO is not empty.
- R7: With `fifo_mode` at 0, `lsr_thre` goes to 1 in the cycle after `tx_load` and to 0 in the cycle after `host_wr_data`. When both happen in one cycle, the write wins.
- R8: With `fifo_mode` at 1, `lsr_thre` is 0 in the cycle after `host_wr_data`. Otherwise it takes the value that `txf_empty` had in the previous cycle.
- R9: `lsr_temt` is 1 only when `lsr_thre` is 1 and `tx_busy` is 0.
- R10: `tx_irq` equals `lsr_thre` AND `thre_ie`.
- R11: After reset `lsr_thre` is 1, and `lsr_oe` and the break-hold state are 0.
- R12: `rxf_pop` is 1 when `host_rd_data` is 1 and `rxf_empty` is 0, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 selects FIFO behaviour for the transmit-empty flag |
| rx_done | input | 1 | Receiver finished a character |
| rx_result | input | 3 | Receiver result: bit0 parity, bit1 framing, bit2 break |
| rx_line | input | 1 | Raw serial input level |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_head_tag | input | 3 | Error tag of the head entry of the receive FIFO |
| host_rd_data | input | 1 | Host reads a received byte |
| host_rd_lsr | input | 1 | Host reads the status register |
| host_wr_data | input | 1 | Host writes a byte to transmit |
| tx_load | input | 1 | Shifter takes a byte from the holding stage |
| txf_empty | input | 1 | Transmit FIFO empty |
| tx_busy | input | 1 | Transmit shift register holds data |
| thre_ie | input | 1 | Transmit-empty interrupt enable |
| rxf_push | output | 1 | Write the character into the receive FIFO |
| rxf_push_tag | output | 3 | Error tag stored with the pushed character |
| rxf_pop | output | 1 | Remove the head entry of the receive FIFO |
| lsr_dr | output | 1 | Data ready |
| lsr_oe | output | 1 | Overrun |
| lsr_pe | output | 1 | Parity error of the head entry |
| lsr_fe | output | 1 | Framing error of the head entry |
| lsr_bi | output | 1 | Break indication |
| lsr_thre | output | 1 | Transmit holding stage empty |
| lsr_temt | output | 1 | Transmitter fully empty |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench drives the FIFO with a full flag and targets a status read that lands in the same cycle as an overrun. A design that gave the clear priority there would lose that overrun. It sends repeated break completions while the line stays low and checks that only the first one is pushed. A design without the hold would fill the FIFO with break characters or report false overruns. It shows the head tag while the FIFO is empty, to catch error bits that are not gated. It also drives a transmit write in the same cycle as a shifter load, so the holding-empty flag must come out as 0.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int TAG_W = 3;
  localparam int TAG_PERR = 0;
  localparam int TAG_FERR = 1;
  localparam int TAG_BRK  = 2;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_tag_t;
endpackage

// File: rtl/uart_lsr_rx.sv
module uart_lsr_rx
  import uart_lsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rx_done,
  input  rx_tag_t rx_tag,
  input  logic    rx_line,
  input  logic    rxf_full,
  input  logic    rxf_empty,
  input  rx_tag_t head_tag,
  input  logic    host_rd_data,
  input  logic    host_rd_lsr,
  output logic    rxf_push,
  output logic    rxf_pop,
  output logic    dr,
  output logic    oe,
  output logic    pe,
  output logic    fe,
  output logic    bi
);
  logic hold_q, hold_d, hold_en;
  logic oe_q, oe_d, oe_en;
  logic dup_brk, accept, ovr_evt;

  // a break completion while the hold is set is a repeat of the same break
  always_comb begin
    dup_brk = rx_done & rx_tag.brk & hold_q;
    accept  = rx_done & ~dup_brk;
    rxf_push = accept & ~rxf_full;
    ovr_evt  = accept & rxf_full;
    rxf_pop  = host_rd_data & ~rxf_empty;
  end

  // next-state: a new overrun wins over a clear in the same cycle
  always_comb begin
    oe_d  = ovr_evt | (oe_q & ~host_rd_lsr);
    oe_en = ovr_evt | host_rd_lsr;
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (rx_done && rx_tag.brk) begin
      hold_d  = 1'b1;
      hold_en = 1'b1;
    end else if (rx_line) begin
      hold_d  = 1'b0;
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (oe_en)   oe_q   <= oe_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  always_comb begin
    dr = ~rxf_empty;
    oe = oe_q;
    pe = ~rxf_empty & head_tag.perr;
    fe = ~rxf_empty & head_tag.ferr;
    bi = hold_q | (~rxf_empty & head_tag.brk);
  end
endmodule

// File: rtl/uart_lsr_tx.sv
module uart_lsr_tx (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic host_wr_data,
  input  logic tx_load,
  input  logic txf_empty,
  input  logic tx_busy,
  input  logic thre_ie,
  output logic thre,
  output logic temt,
  output logic irq
);
  logic thre_q, thre_d, thre_en;

  always_comb begin
    thre_en = 1'b1;
    if (host_wr_data)   thre_d = 1'b0;
    else if (fifo_mode) thre_d = txf_empty;
    else if (tx_load)   thre_d = 1'b1;
    else begin
      thre_d  = thre_q;
      thre_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       thre_q <= 1'b1;
    else if (thre_en) thre_q <= thre_d;
  end

  always_comb begin
    thre = thre_q;
    temt = thre_q & ~tx_busy;
    irq  = thre_q & thre_ie;
  end
endmodule

// File: rtl/uart_lsr_track.sv
module uart_lsr_track
  import uart_lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             rx_done,
  input  logic [TAG_W-1:0] rx_result,
  input  logic             rx_line,
  input  logic             rxf_full,
  input  logic             rxf_empty,
  input  logic [TAG_W-1:0] rxf_head_tag,
  input  logic             host_rd_data,
  input  logic             host_rd_lsr,
  input  logic             host_wr_data,
  input  logic             tx_load,
  input  logic             txf_empty,
  input  logic             tx_busy,
  input  logic             thre_ie,
  output logic             rxf_push,
  output logic [TAG_W-1:0] rxf_push_tag,
  output logic             rxf_pop,
  output logic             lsr_dr,
  output logic             lsr_oe,
  output logic             lsr_pe,
  output logic             lsr_fe,
  output logic             lsr_bi,
  output logic             lsr_thre,
  output logic             lsr_temt,
  output logic             tx_irq
);
  rx_tag_t rx_tag, head_tag;

  assign rx_tag       = rx_tag_t'(rx_result);
  assign head_tag     = rx_tag_t'(rxf_head_tag);
  assign rxf_push_tag = rx_result;

  uart_lsr_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_done      (rx_done),
    .rx_tag       (rx_tag),
    .rx_line      (rx_line),
    .rxf_full     (rxf_full),
    .rxf_empty    (rxf_empty),
    .head_tag     (head_tag),
    .host_rd_data (host_rd_data),
    .host_rd_lsr  (host_rd_lsr),
    .rxf_push     (rxf_push),
    .rxf_pop      (rxf_pop),
    .dr           (lsr_dr),
    .oe           (lsr_oe),
    .pe           (lsr_pe),
    .fe           (lsr_fe),
    .bi           (lsr_bi)
  );

  uart_lsr_tx u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode    (fifo_mode),
    .host_wr_data (host_wr_data),
    .tx_load      (tx_load),
    .txf_empty    (txf_empty),
    .tx_busy      (tx_busy),
    .thre_ie      (thre_ie),
    .thre         (lsr_thre),
    .temt         (lsr_temt),
    .irq          (tx_irq)
  );
endmodule

// File: rtl/uart_lsr_chk.sv
module uart_lsr_chk
  import uart_lsr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_mode,
  input logic             rx_done,
  input logic [TAG_W-1:0] rx_result,
  input logic             rx_line,
  input logic             rxf_full,
  input logic             rxf_empty,
  input logic             host_rd_data,
  input logic             host_rd_lsr,
  input logic             host_wr_data,
  input logic             tx_load,
  input logic             tx_busy,
  input logic             thre_ie,
  input logic             rxf_push,
  input logic [TAG_W-1:0] rxf_push_tag,
  input logic             rxf_pop,
  input logic             lsr_oe,
  input logic             lsr_thre,
  input logic             lsr_temt,
  input logic             tx_irq
);
  p_push_not_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> !rxf_full);

  p_ovr_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_result[TAG_BRK] && rxf_full) |=> lsr_oe);

  p_ovr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_lsr && !rx_done) |=> !lsr_oe);

  p_brk_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_push && rxf_push_tag[TAG_BRK]) |=> !(rxf_push && rxf_push_tag[TAG_BRK]));

  p_wr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_data |=> !lsr_thre);

  p_load_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && tx_load && !host_wr_data) |=> lsr_thre);

  p_temt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_temt |-> (lsr_thre && !tx_busy));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (lsr_thre && thre_ie));

  p_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |-> (host_rd_data && !rxf_empty));
endmodule

bind uart_lsr_track uart_lsr_chk u_chk (.*);

// File: tb/sim_uart_lsr_track.sv
module sim_uart_lsr_track;
  logic clk, rst_n;
  logic fifo_mode, rx_done, rx_line, rxf_full, rxf_empty;
  logic [2:0] rx_result, rxf_head_tag, rxf_push_tag;
  logic host_rd_data, host_rd_lsr, host_wr_data, tx_load, txf_empty, tx_busy, thre_ie;
  logic rxf_push, rxf_pop, lsr_dr, lsr_oe, lsr_pe, lsr_fe, lsr_bi, lsr_thre, lsr_temt, tx_irq;

  localparam int DEPTH = 4;

  uart_lsr_track u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  logic [2:0] q [DEPTH];
  int   cnt;
  logic m_oe, m_hold, m_thre;

  // stimulus set by callers before each cycle
  logic s_mode, s_done, s_line, s_rd, s_lsr, s_wr, s_load, s_txe, s_busy, s_ie;
  logic [2:0] s_res, s_junk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic f_thre(input logic mode, input logic wr, input logic ld,
                                  input logic txe, input logic cur);
    if (wr) return 1'b0;
    if (mode) return txe;
    if (ld) return 1'b1;
    return cur;
  endfunction

  task automatic run_cycle();
    logic e_dup, e_push, e_ovr, e_pop, e_empty;
    logic [2:0] head;
    @(negedge clk);
    e_empty = (cnt == 0);
    head = e_empty ? s_junk : q[0];
    fifo_mode = s_mode; rx_done = s_done; rx_result = s_res; rx_line = s_line;
    rxf_full = (cnt == DEPTH); rxf_empty = e_empty; rxf_head_tag = head;
    host_rd_data = s_rd; host_rd_lsr = s_lsr; host_wr_data = s_wr;
    tx_load = s_load; txf_empty = s_txe; tx_busy = s_busy; thre_ie = s_ie;
    #1;
    e_dup  = s_done & s_res[2] & m_hold;
    e_push = s_done & ~e_dup & (cnt != DEPTH);
    e_ovr  = s_done & ~e_dup & (cnt == DEPTH);
    e_pop  = s_rd & ~e_empty;
    chk("R1", "lsr_dr", lsr_dr, ~e_empty);
    chk("R2", "rxf_push", rxf_push, e_push);
    if (e_push) chk("R4", "rxf_push_tag", rxf_push_tag == s_res, 1'b1);
    chk("R3", "lsr_oe", lsr_oe, m_oe);
    chk("R4", "lsr_pe", lsr_pe, ~e_empty & head[0]);
    chk("R4", "lsr_fe", lsr_fe, ~e_empty & head[1]);
    chk("R6", "lsr_bi", lsr_bi, m_hold | (~e_empty & head[2]));
    chk("R7", "lsr_thre", lsr_thre, m_thre);
    chk("R9", "lsr_temt", lsr_temt, m_thre & ~s_busy);
    chk("R10", "tx_irq", tx_irq, m_thre & s_ie);
    chk("R12", "rxf_pop", rxf_pop, e_pop);
    @(posedge clk);
    // model update
    m_oe = e_ovr | (m_oe & ~s_lsr);
    if (s_done && s_res[2]) m_hold = 1'b1;
    else if (s_line) m_hold = 1'b0;
    m_thre = f_thre(s_mode, s_wr, s_load, s_txe, m_thre);
    if (e_pop) begin
      for (int i = 0; i < DEPTH-1; i++) q[i] = q[i+1];
      cnt--;
    end
    if (e_push) begin
      q[cnt] = s_res;
      cnt++;
    end
  endtask

  task automatic idle();
    s_done = 0; s_res = 0; s_line = 1; s_rd = 0; s_lsr = 0; s_wr = 0;
    s_load = 0; s_txe = 1; s_busy = 0; s_ie = 0; s_junk = 3'b111;
  endtask

  initial begin
    #(4*200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    cnt = 0; m_oe = 0; m_hold = 0; m_thre = 1;
    s_mode = 0; idle();
    fifo_mode = 0; rx_done = 0; rx_result = 0; rx_line = 1; rxf_full = 0; rxf_empty = 1;
    rxf_head_tag = 0; host_rd_data = 0; host_rd_lsr = 0; host_wr_data = 0;
    tx_load = 0; txf_empty = 1; tx_busy = 0; thre_ie = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R11 reset state
    chk("R11", "reset lsr_thre", lsr_thre, 1'b1);
    chk("R11", "reset lsr_oe", lsr_oe, 1'b0);
    chk("R11", "reset lsr_bi", lsr_bi, 1'b0);
    chk("R1", "reset lsr_dr", lsr_dr, 1'b0);

    // R4 junk head tag while empty must not show
    idle(); run_cycle();

    // R2/R3 fill FIFO, overrun coincident with status read
    for (int i = 0; i < DEPTH; i++) begin
      idle(); s_done = 1; s_res = 3'(i); run_cycle();
    end
    idle(); s_done = 1; s_res = 3'b011; s_lsr = 1; run_cycle();
    idle(); run_cycle();                  // R3 overrun kept
    idle(); s_lsr = 1; run_cycle();
    idle(); run_cycle();                  // R3 cleared
    for (int i = 0; i < DEPTH; i++) begin idle(); s_rd = 1; run_cycle(); end

    // R5/R6 repeated break while line low
    idle(); s_line = 0; s_done = 1; s_res = 3'b110; run_cycle();
    for (int i = 0; i < 3; i++) begin
      idle(); s_line = 0; run_cycle();
      idle(); s_line = 0; s_done = 1; s_res = 3'b110; run_cycle();
    end
    idle(); s_line = 1; run_cycle();
    idle(); run_cycle();
    idle(); s_rd = 1; run_cycle();
    idle(); run_cycle();

    // R7 write and load together in holding-register mode
    idle(); s_load = 1; run_cycle();
    idle(); s_load = 1; s_wr = 1; run_cycle();
    idle(); s_busy = 1; s_ie = 1; run_cycle();
    idle(); s_load = 1; s_ie = 1; run_cycle();
    idle(); s_ie = 1; run_cycle();
    // R8 FIFO mode write with empty flag still high
    s_mode = 1;
    idle(); s_wr = 1; s_txe = 1; run_cycle();
    idle(); s_txe = 0; run_cycle();
    idle(); s_txe = 1; run_cycle();
    idle(); run_cycle();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) s_mode = $urandom_range(0, 1);
      s_done = ($urandom_range(0, 3) == 0);
      s_res  = 3'($urandom);
      if ($urandom_range(0, 3) != 0) s_res[2] = 1'b0;
      s_line = ($urandom_range(0, 4) != 0);
      s_rd   = ($urandom_range(0, 4) == 0);
      s_lsr  = ($urandom_range(0, 7) == 0);
      s_wr   = ($urandom_range(0, 3) == 0);
      s_load = ($urandom_range(0, 3) == 0);
      s_txe  = $urandom_range(0, 1);
      s_busy = $urandom_range(0, 1);
      s_ie   = $urandom_range(0, 1);
      s_junk = 3'($urandom);
      run_cycle();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule